// File: doc/BRIEF.md
# Cascaded Timestamp Interrupt Register

This block gathers nine timestamp-capture event sources into one 32-bit memory-mapped word. Each source has a sticky pending flag and a matching enable. A pending flag is set by a one-cycle pulse on its event input. It latches even when its enable is clear. Software clears a flag by writing one to it.

The nine sources are:
- a capture on receive and on transmit for each of three ports;
- two general-purpose input capture events;
- one timer event.

For port 0, which is the host port, "receive" means traffic leaving the switch fabric toward the host. "Transmit" means traffic entering the fabric from the host.

Every source whose flag and enable are both set is folded into one cascade bit of a top-level interrupt status word. That cascade bit has its own enable in a top-level enable word. The system interrupt output is level-sensitive and active-high. It is registered, and it asserts only while the cascade bit and its top-level enable are both set. Timestamp capture and packet matching happen elsewhere. Only their completion pulses arrive here.

Top module: `ts_irq_cascade`

## Requirements
- R1: After reset, every enable and every pending flag is 0, the top-level enable is 0, `irq_o` is 0, and every readable word returns 0.
- R2: The event word (word address 0) returns the nine enables in bits 24:16 and the nine pending flags in bits 8:0. Bits 31:25 and 15:9 read as zero. Source index i sits at status bit i and enable bit 16+i. Index 8 is port 2 receive, 7 is port 2 transmit, 6 is port 1 receive, 5 is port 1 transmit, 4 is host-port receive, 3 is host-port transmit, 2 is the second GPIO capture, 1 is the first GPIO capture, and 0 is the timer.
- R3: A write to the event word loads all nine enables from write-data bits 24:16.
- R4: A pulse on `evt_i[i]` sets pending flag i at that clock edge, whatever the enable. A flag never sets without a pulse.
- R5: A write to the event word clears pending flag i when write-data bit i is 1. A 0 in that position leaves the flag unchanged.
- R6: If an event pulse and a write-one-to-clear hit the same flag in the same cycle, the flag stays set.
- R7: The top-level status word (word address 1) returns in bit 29 the OR over i of (flag i AND enable i). All its other bits are 0. Writes to this word have no effect.
- R8: The top-level enable word (word address 2) stores write-data bit 29 and returns it in bit 29. All its other bits read 0.
- R9: `irq_o` equals, one cycle later, top-level status bit 29 AND top-level enable bit 29. It therefore drops one cycle after the last enabled pending flag is cleared.
- R10: Reads return their data one cycle after the address is presented. Word addresses other than 0, 1 and 2 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 9 | One-cycle event pulses, index per R2 |
| bus_addr | input | 4 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Level, active-high system interrupt |

## Verification
The hardest case to reach is an event pulse and a write-one-to-clear landing on the same flag in the same cycle, since the two normally come from unrelated agents. The bench drives both in one cycle, then reads the word back. The same test is repeated with the pulse on one bit and the clear on a neighbouring bit. A sweep over all 512 enable masks, each paired with a different event pattern and a toggled top-level enable, covers the cascade OR. Clearing a lone enabled flag is checked cycle by cycle to confirm the one-cycle lag of the interrupt drop.

// File: rtl/ts_irq_pkg.sv
package ts_irq_pkg;
  typedef enum logic [1:0] {
    SEL_EVT  = 2'd0,
    SEL_TSTS = 2'd1,
    SEL_TEN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [31:0] addr,
                                          input logic [31:0] a_evt,
                                          input logic [31:0] a_tsts,
                                          input logic [31:0] a_ten);
    if (addr == a_evt)       return SEL_EVT;
    else if (addr == a_tsts) return SEL_TSTS;
    else if (addr == a_ten)  return SEL_TEN;
    else                     return SEL_NONE;
  endfunction
endpackage

// File: rtl/ts_evt_bank.sv
module ts_evt_bank #(
  parameter int NUM_SRC = 9,
  parameter int DATA_W  = 32,
  parameter int EN_LSB  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               wr_evt,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SRC-1:0] sts,
  output logic [NUM_SRC-1:0] en
);
  logic [NUM_SRC-1:0] clr_req;

  assign clr_req = wr_evt ? wdata[NUM_SRC-1:0] : '0;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      // an arriving event wins over a same-cycle clear
      always_ff @(posedge clk) begin
        if (rst)             sts[g] <= 1'b0;
        else if (evt[g])     sts[g] <= 1'b1;
        else if (clr_req[g]) sts[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         en <= '0;
    else if (wr_evt) en <= wdata[EN_LSB +: NUM_SRC];
  end
endmodule

// File: rtl/ts_cascade.sv
module ts_cascade #(
  parameter int NUM_SRC  = 9,
  parameter int DATA_W   = 32,
  parameter int CASC_BIT = 29
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] sts,
  input  logic [NUM_SRC-1:0] en,
  input  logic               wr_ten,
  input  logic [DATA_W-1:0]  wdata,
  output logic               casc,
  output logic               top_en,
  output logic               irq
);
  assign casc = |(sts & en);

  always_ff @(posedge clk) begin
    if (rst) begin
      top_en <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (wr_ten) top_en <= wdata[CASC_BIT];
      irq <= casc & top_en;
    end
  end
endmodule

// File: rtl/ts_rd_mux.sv
module ts_rd_mux
  import ts_irq_pkg::*;
#(
  parameter int NUM_SRC  = 9,
  parameter int DATA_W   = 32,
  parameter int EN_LSB   = 16,
  parameter int CASC_BIT = 29
) (
  input  logic               clk,
  input  logic               rst,
  input  reg_sel_e           sel,
  input  logic [NUM_SRC-1:0] sts,
  input  logic [NUM_SRC-1:0] en,
  input  logic               casc,
  input  logic               top_en,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    unique case (sel)
      SEL_EVT: begin
        nxt[NUM_SRC-1:0]         = sts;
        nxt[EN_LSB +: NUM_SRC]   = en;
      end
      SEL_TSTS: nxt[CASC_BIT]    = casc;
      SEL_TEN:  nxt[CASC_BIT]    = top_en;
      default:  nxt              = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end
endmodule

// File: rtl/ts_irq_cascade.sv
module ts_irq_cascade
  import ts_irq_pkg::*;
#(
  parameter int NUM_SRC   = 9,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int EN_LSB    = 16,
  parameter int CASC_BIT  = 29,
  parameter int ADDR_EVT  = 0,
  parameter int ADDR_TSTS = 1,
  parameter int ADDR_TEN  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);
  localparam int PAD_W = 32 - ADDR_W;

  reg_sel_e           sel;
  logic               wr_evt, wr_ten;
  logic [NUM_SRC-1:0] sts_q, en_q;
  logic               casc, top_en_q;

  assign sel    = decode_sel({{PAD_W{1'b0}}, bus_addr}, ADDR_EVT, ADDR_TSTS, ADDR_TEN);
  assign wr_evt = bus_we && (sel == SEL_EVT);
  assign wr_ten = bus_we && (sel == SEL_TEN);

  ts_evt_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .EN_LSB(EN_LSB)) u_bank (
    .clk(clk), .rst(rst), .evt(evt_i), .wr_evt(wr_evt), .wdata(bus_wdata),
    .sts(sts_q), .en(en_q)
  );

  ts_cascade #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .CASC_BIT(CASC_BIT)) u_casc (
    .clk(clk), .rst(rst), .sts(sts_q), .en(en_q), .wr_ten(wr_ten),
    .wdata(bus_wdata), .casc(casc), .top_en(top_en_q), .irq(irq_o)
  );

  ts_rd_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .EN_LSB(EN_LSB),
              .CASC_BIT(CASC_BIT)) u_rd (
    .clk(clk), .rst(rst), .sel(sel), .sts(sts_q), .en(en_q), .casc(casc),
    .top_en(top_en_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/ts_irq_cascade_chk.sv
module ts_irq_cascade_chk #(
  parameter int NUM_SRC  = 9,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int EN_LSB   = 16,
  parameter int CASC_BIT = 29,
  parameter int ADDR_EVT = 0,
  parameter int ADDR_TSTS = 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] evt_i,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] sts_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic               top_en_q
);
  localparam int RSV_HI_W = DATA_W - EN_LSB - NUM_SRC;
  localparam int RSV_LO_W = EN_LSB - NUM_SRC;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!irq_o && sts_q == '0)); // R1

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past((|(sts_q & en_q)) && top_en_q)); // R9

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_EVT) |->
      (bus_rdata[DATA_W-1 -: RSV_HI_W] == '0 && bus_rdata[NUM_SRC +: RSV_LO_W] == '0)); // R2

  AST_CASC_READ: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_TSTS) |-> (bus_rdata[CASC_BIT] == $past(|(sts_q & en_q)))); // R7

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
      AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        evt_i[g] |=> sts_q[g]); // R6
      AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_q[g]) |-> $past(evt_i[g])); // R4
      AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!evt_i[g] && !(bus_we && bus_addr == ADDR_EVT && bus_wdata[g])) |=> $stable(sts_q[g])); // R5
    end
  endgenerate
endmodule

bind ts_irq_cascade ts_irq_cascade_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EN_LSB(EN_LSB),
  .CASC_BIT(CASC_BIT), .ADDR_EVT(ADDR_EVT), .ADDR_TSTS(ADDR_TSTS)
) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
  .sts_q(sts_q), .en_q(en_q), .top_en_q(top_en_q)
);

// File: tb/tb_ts_irq_cascade.sv
`timescale 1ns/1ps
module tb_ts_irq_cascade;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  evt_i = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  logic [8:0] m_sts = '0, m_en = '0;
  logic       m_ten = 1'b0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  ts_irq_cascade dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    if (a == 4'd0) begin
      m_sts = m_sts & ~d[8:0];
      m_en  = d[24:16];
    end else if (a == 4'd2) begin
      m_ten = d[29];
    end
  endtask

  task automatic rdw(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [8:0] p);
    @(negedge clk);
    evt_i = p;
    @(negedge clk);
    evt_i = '0;
    m_sts = m_sts | p;
  endtask

  function automatic logic [31:0] evt_word();
    return {7'd0, m_en, 7'd0, m_sts};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      rdw(a[3:0], rd);
      chk("R1 read", rd, 32'd0);
    end

    // R3 R2 enable field load and layout
    wr(4'd0, 32'hFFFF_FFFF);
    rdw(4'd0, rd);
    chk("R2 R3 all-ones write", rd, 32'h01FF_0000);

    // R4 status latches with enable off, per source
    wr(4'd0, 32'h0000_01FF);
    for (int i = 0; i < 9; i++) begin
      pulse(9'(1 << i));
      rdw(4'd0, rd);
      chk("R4 single source", rd, evt_word());
    end
    chk("R4 no irq when disabled", {31'd0, irq_o}, 32'd0);

    // R5 write-0 keeps, write-1 clears selectively
    wr(4'd0, 32'h0000_0000);
    rdw(4'd0, rd);
    chk("R5 zero write keeps", rd, 32'h0000_01FF);
    wr(4'd0, 32'h0000_0155);
    rdw(4'd0, rd);
    chk("R5 partial clear", rd, 32'h0000_00AA);

    // R6 pulse and clear same cycle, same bit and neighbour bit
    @(negedge clk);
    bus_addr = 4'd0; bus_we = 1'b1; bus_wdata = 32'h0000_01FF; evt_i = 9'h004;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; evt_i = '0;
    m_sts = 9'h004; m_en = '0;
    rdw(4'd0, rd);
    chk("R6 event beats clear", rd, evt_word());
    @(negedge clk);
    bus_we = 1'b1; bus_wdata = 32'h0000_0004; evt_i = 9'h008;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; evt_i = '0;
    m_sts = 9'h008;
    rdw(4'd0, rd);
    chk("R6 neighbour clear", rd, evt_word());

    // R8 top enable storage
    wr(4'd2, 32'hFFFF_FFFF);
    rdw(4'd2, rd);
    chk("R8 top enable", rd, 32'h2000_0000);

    // R7 R9 sweep all enable masks
    for (int m = 0; m < 512; m++) begin
      logic [8:0] p;
      logic       c;
      p = 9'((m * 37 + 11) & 9'h1FF);
      wr(4'd2, {2'b0, m[1], 29'd0});
      wr(4'd0, {7'd0, m[8:0], 7'd0, 9'h1FF});
      pulse(p);
      c = |(m_sts & m_en);
      rdw(4'd0, rd);
      chk("R2 R3 sweep event word", rd, evt_word());
      rdw(4'd1, rd);
      chk("R7 cascade bit", rd, {2'b0, c, 29'd0});
      chk("R9 irq level", {31'd0, irq_o}, {31'd0, c & m_ten});
    end

    // R7 writes to top status ignored
    wr(4'd2, 32'h2000_0000);
    wr(4'd0, 32'h0001_01FF);
    pulse(9'h001);
    wr(4'd1, 32'h0000_0000);
    rdw(4'd1, rd);
    chk("R7 read-only", rd, 32'h2000_0000);

    // R9 deassert timing
    chk("R9 irq high", {31'd0, irq_o}, 32'd1);
    @(negedge clk);
    bus_addr = 4'd0; bus_we = 1'b1; bus_wdata = 32'h0001_0001;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    m_sts = '0;
    chk("R9 one-cycle lag", {31'd0, irq_o}, 32'd1);
    @(negedge clk);
    chk("R9 drop", {31'd0, irq_o}, 32'd0);

    // R10 unmapped address
    pulse(9'h003);
    for (int a = 3; a < 16; a++) begin
      wr(a[3:0], 32'hFFFF_FFFF);
      rdw(a[3:0], rd);
      chk("R10 unmapped read", rd, 32'd0);
    end
    rdw(4'd0, rd);
    chk("R10 unmapped write ignored", rd, evt_word());
    rdw(4'd2, rd);
    chk("R10 top enable untouched", rd, 32'h2000_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule